// File: doc/BRIEF.md
# Increment-and-Skip Execution Unit

This unit executes the two conditional increment instructions of an 8-bit accumulator-style core. Both instructions add one to a file register. One skips when the result is zero and the other skips when the result is nonzero. The unit decodes a 16-bit instruction word and forms a 12-bit file address from either the fixed low/high access window or the 4-bit bank select value. It reads the operand over a combinational file-register port and increments it. The result goes either to the working register W, which the unit holds, or back to the file register. All of this happens in the cycle in which the instruction is accepted.

When a skip is taken, the already-fetched next instruction must be discarded. The unit raises `squash` for one cycle if that instruction is a single word. It raises `squash` for two cycles if the fetch side reports it as a two-word instruction. No writes take place while `squash` is high, and no instruction is accepted. The unit accepts a new instruction again in the cycle right after the last squash cycle.

The control is a three-state machine:
- `ST_EXEC` executes the instruction and is the ready state.
- `ST_SQUASH_HEAD` is the first discarded cycle.
- `ST_SQUASH_TAIL` is the second discarded cycle, used only for a two-word victim.

The transitions are:
- EXEC→EXEC when there is no skip or no valid instruction.
- EXEC→SQUASH_HEAD when a skip is taken. The two-word flag is latched at this point.
- SQUASH_HEAD→EXEC when the latched flag is clear.
- SQUASH_HEAD→SQUASH_TAIL when the latched flag is set.
- SQUASH_TAIL→EXEC always.

Top module: `incskip_unit`

## Requirements
- R1: Only instruction words whose top six bits are 001111 (skip-on-zero) or 010010 (skip-on-nonzero) are executed. Any other word leaves `fr_we` low, `w_out` unchanged and `squash` low.
- R2: The result is the file operand plus one, modulo 256, so 0xFF gives 0x00.
- R3: Bit 9 (d) selects the destination. With d=1, `fr_we` is high in the accept cycle with `fr_wdata` equal to the result, and W is unchanged. With d=0, `fr_we` stays low and `w_out` shows the result from the next cycle on.
- R4: With bit 8 (a) = 0, the address is the access window. Bits 7:0 below 0x80 map to bank 0x0 and bits 7:0 of 0x80 and above map to bank 0xF; `bank_sel` is ignored.
- R5: With a=1, `fr_addr` is {`bank_sel`, bits 7:0}.
- R6: The skip-on-zero instruction raises `squash` in the next cycle exactly when the result is 0x00.
- R7: The skip-on-nonzero instruction raises `squash` in the next cycle exactly when the result is not 0x00.
- R8: After a skip, `squash` stays high for one cycle if `next_two_word` was low in the accept cycle, and for two cycles if it was high. `ready` returns high in the following cycle, and an instruction presented then is executed.
- R9: While `squash` is high, a valid instruction is ignored: `fr_we` stays low and `w_out` does not change.
- R10: After reset, `w_out` is 0x00, `squash` is low and `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is present |
| instr_word | input | 16 | Instruction word |
| next_two_word | input | 1 | The fetched next instruction occupies two words |
| bank_sel | input | 4 | Bank select register value |
| fr_rdata | input | 8 | File register read data (combinational on fr_addr) |
| fr_addr | output | 12 | Resolved file register address |
| fr_we | output | 1 | File register write enable |
| fr_wdata | output | 8 | File register write data |
| w_out | output | 8 | Working register W |
| squash | output | 1 | Discard the current fetched instruction |
| ready | output | 1 | Unit accepts an instruction this cycle |

## Verification
The bench targets the increment wrap at 0xFF and the two skip senses on both sides of zero. A unit with the senses swapped or without the wrap squashes the wrong instructions. It also targets the access-window split at 0x7F/0x80 and the bank select applied only when a=1; an inverted a bit or a wrong split sends reads and writes to the wrong bank. The squash length is checked for single- and two-word victims, and against a two-word flag given with no skip; an off-by-one state machine either eats a good instruction or runs a discarded one. Finally, valid instructions are presented during squash cycles, where a unit that ignored the squash would write the file register or W.

// File: rtl/incskip_pkg.sv
package incskip_pkg;

    typedef enum logic [1:0] {
        ST_EXEC        = 2'd0,
        ST_SQUASH_HEAD = 2'd1,
        ST_SQUASH_TAIL = 2'd2
    } isk_state_e;

    localparam logic [5:0] OPC_SKIP_ZERO = 6'b001111;
    localparam logic [5:0] OPC_SKIP_NZ   = 6'b010010;

    typedef struct packed {
        logic       hit;
        logic       skip_on_zero;
        logic       to_file;
        logic       banked;
        logic [7:0] fsel;
    } isk_dec_t;

endpackage

// File: rtl/isk_decode.sv
module isk_decode
    import incskip_pkg::*;
(
    input  logic [15:0] instr_word,
    output isk_dec_t    dec
);
    logic [5:0] opc;

    always_comb begin
        opc              = instr_word[15:10];
        dec.hit          = (opc == OPC_SKIP_ZERO) || (opc == OPC_SKIP_NZ);
        dec.skip_on_zero = (opc == OPC_SKIP_ZERO);
        dec.to_file      = instr_word[9];
        dec.banked       = instr_word[8];
        dec.fsel         = instr_word[7:0];
    end
endmodule

// File: rtl/isk_bank_resolve.sv
module isk_bank_resolve #(
    parameter int                BANK_W         = 4,
    parameter logic [7:0]        ACCESS_SPLIT   = 8'h80,
    parameter logic [BANK_W-1:0] ACCESS_HI_BANK = '1,
    localparam int               FADDR_W        = BANK_W + 8
) (
    input  logic               banked,
    input  logic [7:0]         fsel,
    input  logic [BANK_W-1:0]  bank_sel,
    output logic [FADDR_W-1:0] addr
);
    always_comb begin
        if (banked) begin
            addr = {bank_sel, fsel};
        end else if (fsel >= ACCESS_SPLIT) begin
            addr = {ACCESS_HI_BANK, fsel};
        end else begin
            addr = {{BANK_W{1'b0}}, fsel};
        end
    end
endmodule

// File: rtl/isk_squash_fsm.sv
module isk_squash_fsm
    import incskip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_skip,
    input  logic long_next,
    output logic squash,
    output logic ready
);
    isk_state_e state_q, state_d;
    logic       tail_pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_EXEC;
            tail_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_EXEC && start_skip) begin
                tail_pend_q <= long_next;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EXEC:        state_d = start_skip ? ST_SQUASH_HEAD : ST_EXEC;
            ST_SQUASH_HEAD: state_d = tail_pend_q ? ST_SQUASH_TAIL : ST_EXEC;
            ST_SQUASH_TAIL: state_d = ST_EXEC;
            default:        state_d = ST_EXEC;
        endcase
    end

    always_comb begin
        squash = (state_q != ST_EXEC);
        ready  = (state_q == ST_EXEC);
    end

    assert_tail_after_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SQUASH_TAIL) |-> ($past(state_q) == ST_SQUASH_HEAD));

    assert_short_squash_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SQUASH_HEAD && !tail_pend_q) |=> (state_q == ST_EXEC));

    assert_tail_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SQUASH_TAIL) |=> (state_q == ST_EXEC));
endmodule

// File: rtl/incskip_unit.sv
module incskip_unit
    import incskip_pkg::*;
#(
    parameter int                BANK_W         = 4,
    parameter logic [7:0]        ACCESS_SPLIT   = 8'h80,
    parameter logic [BANK_W-1:0] ACCESS_HI_BANK = '1,
    localparam int               FADDR_W        = BANK_W + 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [15:0]        instr_word,
    input  logic               next_two_word,
    input  logic [BANK_W-1:0]  bank_sel,
    input  logic [7:0]         fr_rdata,
    output logic [FADDR_W-1:0] fr_addr,
    output logic               fr_we,
    output logic [7:0]         fr_wdata,
    output logic [7:0]         w_out,
    output logic               squash,
    output logic               ready
);
    isk_dec_t   dec;
    logic       exec;
    logic       want_skip;
    logic [7:0] incr;
    logic [7:0] w_q;

    isk_decode u_decode (
        .instr_word (instr_word),
        .dec        (dec)
    );

    isk_bank_resolve #(
        .BANK_W         (BANK_W),
        .ACCESS_SPLIT   (ACCESS_SPLIT),
        .ACCESS_HI_BANK (ACCESS_HI_BANK)
    ) u_bank (
        .banked   (dec.banked),
        .fsel     (dec.fsel),
        .bank_sel (bank_sel),
        .addr     (fr_addr)
    );

    isk_squash_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_skip (exec && want_skip),
        .long_next  (next_two_word),
        .squash     (squash),
        .ready      (ready)
    );

    always_comb begin
        exec      = instr_valid && ready && dec.hit;
        incr      = fr_rdata + 8'd1;
        want_skip = dec.skip_on_zero ? (incr == 8'h00) : (incr != 8'h00);
        fr_we     = exec && dec.to_file;
        fr_wdata  = incr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= 8'h00;
        end else if (exec && !dec.to_file) begin
            w_q <= incr;
        end
    end

    assign w_out = w_q;

    assert_wdata_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fr_we |-> (fr_wdata == fr_rdata + 8'd1));

    assert_file_dest_keeps_w_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fr_we |=> $stable(w_out));

    assert_access_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !instr_word[8]) |->
            (fr_addr[FADDR_W-1:8] == (instr_word[7] ? ACCESS_HI_BANK : {BANK_W{1'b0}})));

    assert_banked_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_word[8]) |-> (fr_addr[FADDR_W-1:8] == bank_sel));

    assert_zero_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && dec.skip_on_zero) |=> (squash == ($past(fr_rdata) == 8'hFF)));

    assert_nonzero_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !dec.skip_on_zero) |=> (squash == ($past(fr_rdata) != 8'hFF)));

    assert_no_write_in_squash_R9: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> !fr_we);

    assert_w_frozen_in_squash_R9: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> $stable(w_out));
endmodule

// File: tb/test_incskip_unit.sv
module test_incskip_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [15:0] instr_word;
    logic        next_two_word;
    logic [3:0]  bank_sel;
    logic [7:0]  fr_rdata;
    logic [11:0] fr_addr;
    logic        fr_we;
    logic [7:0]  fr_wdata;
    logic [7:0]  w_out;
    logic        squash;
    logic        ready;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    incskip_unit i_incskip_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_valid   (instr_valid),
        .instr_word    (instr_word),
        .next_two_word (next_two_word),
        .bank_sel      (bank_sel),
        .fr_rdata      (fr_rdata),
        .fr_addr       (fr_addr),
        .fr_we         (fr_we),
        .fr_wdata      (fr_wdata),
        .w_out         (w_out),
        .squash        (squash),
        .ready         (ready)
    );

    // instr, bsr, rdata, two-word, exp addr, exp we, W updated, exp value, squash cycles
    localparam int NV = 9;
    localparam logic [52:0] VEC [NV] = '{
        {16'h3E25, 4'h3, 8'h10, 1'b0, 12'h025, 1'b1, 1'b0, 8'h11, 2'd0}, // R1 R3 R6 no skip
        {16'h3E90, 4'h3, 8'hFF, 1'b0, 12'hF90, 1'b1, 1'b0, 8'h00, 2'd1}, // R2 R4 R6 wrap
        {16'h3D90, 4'h5, 8'hFF, 1'b1, 12'h590, 1'b0, 1'b1, 8'h00, 2'd2}, // R3 R5 R8 long
        {16'h4B7F, 4'hA, 8'h41, 1'b1, 12'hA7F, 1'b1, 1'b0, 8'h42, 2'd2}, // R7 R5 long
        {16'h487F, 4'h9, 8'hFF, 1'b0, 12'h07F, 1'b0, 1'b1, 8'h00, 2'd0}, // R7 R4 no skip
        {16'h4880, 4'h2, 8'h00, 1'b0, 12'hF80, 1'b0, 1'b1, 8'h01, 2'd1}, // R7 R4 split
        {16'h3D00, 4'hF, 8'h7F, 1'b1, 12'hF00, 1'b0, 1'b1, 8'h80, 2'd0}, // R8 flag w/o skip
        {16'h3A25, 4'h0, 8'hFF, 1'b1, 12'h000, 1'b0, 1'b0, 8'h00, 2'd0}, // R1 other opcode
        {16'h4C10, 4'h0, 8'hFF, 1'b0, 12'h000, 1'b0, 1'b0, 8'h00, 2'd0}  // R1 other opcode
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] w_exp;
        int         n;
        rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0;
        next_two_word = 1'b0; bank_sel = '0; fr_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 w after reset", w_out, 8'h00);
        chk("R10 squash after reset", squash, 1'b0);
        chk("R10 ready after reset", ready, 1'b1);
        chk("R10 no write when idle", fr_we, 1'b0);
        w_exp = 8'h00;

        for (int i = 0; i < NV; i++) begin
            instr_word    = VEC[i][52:37];
            bank_sel      = VEC[i][36:33];
            fr_rdata      = VEC[i][32:25];
            next_two_word = VEC[i][24];
            instr_valid   = 1'b1;
            #1;
            if (VEC[i][11] || VEC[i][10])
                chk("R4/R5 address", fr_addr, VEC[i][23:12]);
            chk("R1/R3 write enable", fr_we, VEC[i][11]);
            if (VEC[i][11])
                chk("R2/R3 write data", fr_wdata, VEC[i][9:2]);
            @(posedge clk);
            @(negedge clk);
            instr_valid = 1'b0;
            if (VEC[i][10]) w_exp = VEC[i][9:2];
            chk("R1/R3 W value", w_out, w_exp);
            n = 0;
            while (squash && n < 4) begin
                n++;
                @(negedge clk);
            end
            chk("R6/R7/R8 squash cycles", n, VEC[i][1:0]);
            chk("R8 ready after squash", ready, 1'b1);
        end

        // R9: instructions during a two-cycle squash are dropped
        instr_word = 16'h3C10; bank_sel = 4'h0; fr_rdata = 8'hFF;
        next_two_word = 1'b1; instr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        w_exp = 8'h00;
        chk("R9 squash head", squash, 1'b1);
        instr_word = 16'h3E20; fr_rdata = 8'h05; next_two_word = 1'b0;
        #1;
        chk("R9 no file write in squash", fr_we, 1'b0);
        @(negedge clk);
        chk("R8 squash tail", squash, 1'b1);
        instr_word = 16'h3C20;
        #1;
        chk("R9 no file write in tail", fr_we, 1'b0);
        @(negedge clk);
        chk("R9 W unchanged by squashed words", w_out, w_exp);
        chk("R8 ready right after tail", ready, 1'b1);
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R8 back-to-back accept", w_out, 8'h06);
        chk("R6 no skip on nonzero", squash, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule